// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits on the host side of a 16-bit parallel NOR flash bus and turns one request into the ordered write cycles the flash needs for a word program or an erase. A request carries a 2-bit operation code, a target address and a data word. Once the request is accepted, the block raises the write-protect pin and waits out a guard window. It then plays out a fixed unlock prefix followed by an operation-specific tail, one bus write at a time, waits a second guard window and pulses `done`. The flash starts its internal operation after the last write. The sequencer does not wait for that operation to finish.

Each bus write has three timed phases: address and data setup with the strobe high, the strobe low, and a hold with the strobe high. Each phase length is a parameter in clock cycles. Either the write-enable or the chip-enable pin can serve as the strobe. A select input chooses which one pulses; the other is held low for the whole request. The output-enable pin stays high throughout. The guard window is given in microseconds and converted to cycles from a clock-frequency parameter: `GUARD = (CLK_HZ / 1_000_000) * GUARD_US`.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset and whenever idle, `fl_chip_en_n`, `fl_write_en_n` and `fl_out_en_n` are 1, and `fl_protect_n`, `busy` and `done` are 0.
- R2: Operation code 2'b00 (program) produces four writes as (address, data): (0x5555, 0x00AA), (0x2AAA, 0x0055), (0x5555, 0x00A0), then (target address, target data). Every command byte is driven with an upper byte of zero.
- R3: Operation code 2'b01 (whole-chip erase) produces six writes: (0x5555, 0x00AA), (0x2AAA, 0x0055), (0x5555, 0x0080), (0x5555, 0x00AA), (0x2AAA, 0x0055), (0x5555, 0x0010).
- R4: Operation code 2'b10 (block erase) produces the first five writes of R3, then (target address, 0x0050).
- R5: Operation code 2'b11 (sector erase) produces the first five writes of R3, then (target address, 0x0030).
- R6: With `use_chip_strobe` = 0 at request time, `fl_write_en_n` pulses and `fl_chip_en_n` is held 0 while busy. With it at 1, the roles swap. `fl_out_en_n` is always 1.
- R7: Address and data are stable for at least SETUP_CYC cycles before each strobe falling edge and stay unchanged while the strobe is low. The strobe is low for exactly LOW_CYC cycles. Address and data stay unchanged for at least HOLD_CYC cycles after the rising edge.
- R8: `fl_protect_n` is 1 for at least GUARD cycles before the first strobe falling edge and for at least GUARD cycles after the last rising edge. It is 1 whenever the strobe is low.
- R9: `done` is high for exactly one cycle per request, with `busy` low in that cycle. `busy` is high for exactly 2*GUARD + N*(SETUP_CYC+LOW_CYC+HOLD_CYC) cycles, where N is the write count.
- R10: A request presented while busy, including in the final trailing-guard cycle, is ignored and leaves the running sequence unchanged. A request present in the cycle `done` is high is accepted, so `busy` is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled only when idle |
| req_op | input | 2 | Operation code (see R2 to R5) |
| req_addr | input | ADDR_W | Target address for program, block or sector erase |
| req_data | input | DATA_W | Word to program |
| use_chip_strobe | input | 1 | 0 selects write-enable as the strobe, 1 selects chip-enable |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_data | output | DATA_W | Flash data bus (write only) |
| fl_chip_en_n | output | 1 | Chip enable, active low |
| fl_write_en_n | output | 1 | Write enable, active low |
| fl_out_en_n | output | 1 | Output enable, active low (held high) |
| fl_protect_n | output | 1 | Write-protect pin; 1 releases protection |

## Verification
Two events can fall in the same cycle: the end of one sequence (the `done` pulse) and the arrival of the next request. The bench holds `req_valid` high through an entire program sequence. This tests two things: that every cycle of that request, up to and including the final trailing-guard cycle, is ignored, and that the request becomes valid exactly in the cycle `done` is visible. The result is judged from the pins. `busy` must be 1 in the cycle after `done`, and the bus must then carry two complete four-write sequences with one `done` each. Separately, the bench sends conflicting requests during a running sequence and compares the logged writes against the expected list.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROGRAM      = 2'b00,
    OP_CHIP_ERASE   = 2'b01,
    OP_BLOCK_ERASE  = 2'b10,
    OP_SECTOR_ERASE = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_TRAIL
  } phase_e;

  localparam logic [15:0] ADR_MAGIC_P = 16'h5555;
  localparam logic [15:0] ADR_MAGIC_Q = 16'h2AAA;

  localparam logic [7:0] CMD_KEY_P    = 8'hAA;
  localparam logic [7:0] CMD_KEY_Q    = 8'h55;
  localparam logic [7:0] CMD_WORD_WR  = 8'hA0;
  localparam logic [7:0] CMD_ERASE_EN = 8'h80;
  localparam logic [7:0] CMD_ALL      = 8'h10;
  localparam logic [7:0] CMD_BLOCK    = 8'h50;
  localparam logic [7:0] CMD_SECTOR   = 8'h30;

  localparam logic [2:0] LAST_IDX_PROGRAM = 3'd3;
  localparam logic [2:0] LAST_IDX_ERASE   = 3'd5;

endpackage

// File: rtl/flash_phase_timer.sv
module flash_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire = (cnt_q == '0);

endmodule

// File: rtl/flash_cmd_table.sv
module flash_cmd_table
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16
) (
  input  op_e               op,
  input  logic [2:0]        idx,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [DATA_W-1:0] tgt_data,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic [DATA_W-1:0] cyc_data
);

  localparam logic [ADDR_W-1:0] A_P = ADDR_W'(ADR_MAGIC_P);
  localparam logic [ADDR_W-1:0] A_Q = ADDR_W'(ADR_MAGIC_Q);

  always_comb begin
    cyc_addr = A_P;
    cyc_data = DATA_W'(CMD_KEY_P);
    case (idx)
      3'd1, 3'd4: begin
        cyc_addr = A_Q;
        cyc_data = DATA_W'(CMD_KEY_Q);
      end
      3'd2: begin
        cyc_data = (op == OP_PROGRAM) ? DATA_W'(CMD_WORD_WR) : DATA_W'(CMD_ERASE_EN);
      end
      3'd3: begin
        if (op == OP_PROGRAM) begin
          cyc_addr = tgt_addr;
          cyc_data = tgt_data;
        end
      end
      3'd5: begin
        case (op)
          OP_BLOCK_ERASE: begin
            cyc_addr = tgt_addr;
            cyc_data = DATA_W'(CMD_BLOCK);
          end
          OP_SECTOR_ERASE: begin
            cyc_addr = tgt_addr;
            cyc_data = DATA_W'(CMD_SECTOR);
          end
          default: begin
            cyc_data = DATA_W'(CMD_ALL);
          end
        endcase
      end
      default: begin
        cyc_addr = A_P;
        cyc_data = DATA_W'(CMD_KEY_P);
      end
    endcase
  end

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int GUARD_CYC = 100,
  parameter int SETUP_CYC = 2,
  parameter int LOW_CYC   = 3,
  parameter int HOLD_CYC  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  op_e              op_q,
  input  logic             expire,
  output phase_e           phase_q,
  output phase_e           phase_d,
  output logic [2:0]       idx_d,
  output logic             load,
  output logic [CNT_W-1:0] load_val
);

  localparam logic [CNT_W-1:0] LD_GUARD = CNT_W'(GUARD_CYC - 1);
  localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_LOW   = CNT_W'(LOW_CYC - 1);
  localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(HOLD_CYC - 1);

  logic [2:0] idx_q;
  logic       last_word;

  assign last_word = (op_q == OP_PROGRAM) ? (idx_q == LAST_IDX_PROGRAM)
                                          : (idx_q == LAST_IDX_ERASE);

  always_comb begin
    phase_d  = phase_q;
    idx_d    = idx_q;
    load     = 1'b0;
    load_val = '0;
    case (phase_q)
      PH_IDLE: begin
        if (req_valid) begin
          phase_d  = PH_LEAD;
          idx_d    = 3'd0;
          load     = 1'b1;
          load_val = LD_GUARD;
        end
      end
      PH_LEAD: begin
        if (expire) begin
          phase_d  = PH_SETUP;
          load     = 1'b1;
          load_val = LD_SETUP;
        end
      end
      PH_SETUP: begin
        if (expire) begin
          phase_d  = PH_STROBE;
          load     = 1'b1;
          load_val = LD_LOW;
        end
      end
      PH_STROBE: begin
        if (expire) begin
          phase_d  = PH_HOLD;
          load     = 1'b1;
          load_val = LD_HOLD;
        end
      end
      PH_HOLD: begin
        if (expire) begin
          load = 1'b1;
          if (last_word) begin
            phase_d  = PH_TRAIL;
            load_val = LD_GUARD;
          end else begin
            phase_d  = PH_SETUP;
            idx_d    = idx_q + 3'd1;
            load_val = LD_SETUP;
          end
        end
      end
      PH_TRAIL: begin
        if (expire) begin
          phase_d = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      idx_q   <= 3'd0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
    end
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int DATA_W    = 16,
  parameter int SETUP_CYC = 2,
  parameter int LOW_CYC   = 3,
  parameter int HOLD_CYC  = 2,
  parameter int CLK_HZ    = 100_000_000,
  parameter int GUARD_US  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              use_chip_strobe,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_data,
  output logic              fl_chip_en_n,
  output logic              fl_write_en_n,
  output logic              fl_out_en_n,
  output logic              fl_protect_n
);

  localparam int GUARD_CYC = (CLK_HZ / 1_000_000) * GUARD_US;
  localparam int MAX_SL    = (SETUP_CYC > LOW_CYC) ? SETUP_CYC : LOW_CYC;
  localparam int MAX_HG    = (HOLD_CYC > GUARD_CYC) ? HOLD_CYC : GUARD_CYC;
  localparam int MAX_CYC   = (MAX_SL > MAX_HG) ? MAX_SL : MAX_HG;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  phase_e             phase_q, phase_d;
  logic [2:0]         idx_d;
  logic               load, expire;
  logic [CNT_W-1:0]   load_val;
  logic               accept;

  op_e                op_q;
  logic [ADDR_W-1:0]  tgt_addr_q;
  logic [DATA_W-1:0]  tgt_data_q;
  logic               mode_q, mode_d;
  logic [ADDR_W-1:0]  cyc_addr;
  logic [DATA_W-1:0]  cyc_data;
  logic               active_d, strobe_d, word_start;

  assign accept = (phase_q == PH_IDLE) && req_valid;

  flash_seq_ctrl #(
    .CNT_W    (CNT_W),
    .GUARD_CYC(GUARD_CYC),
    .SETUP_CYC(SETUP_CYC),
    .LOW_CYC  (LOW_CYC),
    .HOLD_CYC (HOLD_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .op_q     (op_q),
    .expire   (expire),
    .phase_q  (phase_q),
    .phase_d  (phase_d),
    .idx_d    (idx_d),
    .load     (load),
    .load_val (load_val)
  );

  flash_phase_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .load_val(load_val),
    .expire  (expire)
  );

  flash_cmd_table #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_table (
    .op      (op_q),
    .idx     (idx_d),
    .tgt_addr(tgt_addr_q),
    .tgt_data(tgt_data_q),
    .cyc_addr(cyc_addr),
    .cyc_data(cyc_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q       <= OP_PROGRAM;
      tgt_addr_q <= '0;
      tgt_data_q <= '0;
      mode_q     <= 1'b0;
    end else if (accept) begin
      op_q       <= op_e'(req_op);
      tgt_addr_q <= req_addr;
      tgt_data_q <= req_data;
      mode_q     <= use_chip_strobe;
    end
  end

  assign mode_d     = accept ? use_chip_strobe : mode_q;
  assign active_d   = (phase_d != PH_IDLE);
  assign strobe_d   = (phase_d == PH_STROBE);
  assign word_start = (phase_d == PH_SETUP) && (phase_q != PH_SETUP);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy          <= 1'b0;
      done          <= 1'b0;
      fl_addr       <= '0;
      fl_data       <= '0;
      fl_chip_en_n  <= 1'b1;
      fl_write_en_n <= 1'b1;
      fl_out_en_n   <= 1'b1;
      fl_protect_n  <= 1'b0;
    end else begin
      busy          <= active_d;
      done          <= (phase_q == PH_TRAIL) && (phase_d == PH_IDLE);
      fl_protect_n  <= active_d;
      fl_out_en_n   <= 1'b1;
      fl_chip_en_n  <= mode_d ? !strobe_d : !active_d;
      fl_write_en_n <= mode_d ? !active_d : !strobe_d;
      if (word_start) begin
        fl_addr <= cyc_addr;
        fl_data <= cyc_data;
      end
    end
  end

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] fl_addr,
  input logic [DATA_W-1:0] fl_data,
  input logic              fl_chip_en_n,
  input logic              fl_write_en_n,
  input logic              fl_out_en_n,
  input logic              fl_protect_n
);

  logic both_low;
  assign both_low = !fl_chip_en_n && !fl_write_en_n;

  assert_idle_strobes_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (fl_chip_en_n && fl_write_en_n));

  assert_out_en_high_R6: assert property (@(posedge clk) disable iff (rst)
    busy |-> fl_out_en_n);

  assert_bus_stable_low_R7: assert property (@(posedge clk) disable iff (rst)
    (both_low && $past(both_low)) |-> ($stable(fl_addr) && $stable(fl_data)));

  assert_protect_at_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    both_low |-> fl_protect_n);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .busy         (busy),
  .done         (done),
  .fl_addr      (fl_addr),
  .fl_data      (fl_data),
  .fl_chip_en_n (fl_chip_en_n),
  .fl_write_en_n(fl_write_en_n),
  .fl_out_en_n  (fl_out_en_n),
  .fl_protect_n (fl_protect_n)
);

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;

  localparam int AW = 21;
  localparam int DW = 16;
  localparam int S  = 2;
  localparam int L  = 3;
  localparam int H  = 2;
  localparam int HZ = 3_000_000;
  localparam int GU = 1;
  localparam int G  = (HZ / 1_000_000) * GU;
  localparam int T  = S + L + H;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          use_chip_strobe = 1'b0;
  logic          busy, done;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_data;
  logic          fl_chip_en_n, fl_write_en_n, fl_out_en_n, fl_protect_n;

  flash_cmd_seq #(
    .ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(S), .LOW_CYC(L),
    .HOLD_CYC(H), .CLK_HZ(HZ), .GUARD_US(GU)
  ) i_flash_cmd_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .use_chip_strobe(use_chip_strobe),
    .busy(busy), .done(done), .fl_addr(fl_addr), .fl_data(fl_data),
    .fl_chip_en_n(fl_chip_en_n), .fl_write_en_n(fl_write_en_n),
    .fl_out_en_n(fl_out_en_n), .fl_protect_n(fl_protect_n)
  );

  always #5 clk = ~clk;

  int nchk = 0;
  int nfail = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor state
  logic [AW+DW-1:0] log_ad [0:15];
  int  nw = 0, done_cnt = 0, busy_run = 0, lat_last = 0;
  bit  mode_cur = 1'b0;
  logic [AW+DW-1:0] prev_ad, fall_ad, cur_ad;
  int  run_same, since_rise, low_run, wp_run, post_run;
  bit  hold_armed, low_moved, post_armed, prev_stb, prev_wp, prev_done;
  bit  stb, oth;

  always @(negedge clk) begin
    if (rst) begin
      prev_ad = '0; run_same = 0; since_rise = 0; low_run = 0; wp_run = 0;
      post_run = 0; hold_armed = 0; low_moved = 0; post_armed = 0;
      prev_stb = 1; prev_wp = 0; prev_done = 0;
    end else begin
      cur_ad   = {fl_addr, fl_data};
      stb      = mode_cur ? fl_chip_en_n : fl_write_en_n;
      oth      = mode_cur ? fl_write_en_n : fl_chip_en_n;
      run_same = (cur_ad == prev_ad) ? run_same + 1 : 1;
      wp_run   = fl_protect_n ? wp_run + 1 : 0;
      if (busy) busy_run++;
      if (prev_stb && !stb) begin
        chk(run_same >= S + 1, "R7 setup before strobe fall", run_same, S + 1);
        if (nw == 0) chk(wp_run >= G + 1, "R8 leading guard", wp_run, G + 1);
        chk(oth == 1'b0 && fl_out_en_n == 1'b1, "R6 idle strobe low, out-enable high",
            {oth, fl_out_en_n}, 2'b01);
        if (nw < 16) log_ad[nw] = cur_ad;
        nw++;
        low_run = 0; low_moved = 0; fall_ad = cur_ad; hold_armed = 0;
      end
      if (!stb) begin
        low_run++;
        if (cur_ad != fall_ad) low_moved = 1;
      end
      if (!prev_stb && stb) begin
        chk(low_run == L && !low_moved, "R7 strobe low width", low_run, L);
        since_rise = 1; hold_armed = 1; post_run = 1; post_armed = 1;
      end else begin
        if (hold_armed && stb) begin
          if (cur_ad == prev_ad) since_rise++;
          else begin
            chk(since_rise >= H, "R7 hold after strobe rise", since_rise, H);
            hold_armed = 0;
          end
        end
        if (post_armed && fl_protect_n) post_run++;
      end
      if (prev_wp && !fl_protect_n && post_armed) begin
        chk(post_run >= G, "R8 trailing guard", post_run, G);
        post_armed = 0;
      end
      if (prev_done) chk(!done, "R9 done one cycle", done, 0);
      if (done) begin
        done_cnt++;
        lat_last = busy_run;
        busy_run = 0;
        chk(!busy, "R9 busy low with done", busy, 0);
      end
      prev_ad = cur_ad; prev_stb = stb; prev_wp = fl_protect_n; prev_done = done;
    end
  end

  function automatic logic [AW+DW-1:0] exp_ad(input int op, input int i,
                                              input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [AW-1:0] pa = AW'(16'h5555);
    logic [AW-1:0] qa = AW'(16'h2AAA);
    case (i)
      0, 3: begin
        if (i == 3 && op == 0) return {a, d};
        return {pa, DW'(8'hAA)};
      end
      1, 4: return {qa, DW'(8'h55)};
      2: return {pa, (op == 0) ? DW'(8'hA0) : DW'(8'h80)};
      default: begin
        if (op == 1) return {pa, DW'(8'h10)};
        if (op == 2) return {a, DW'(8'h50)};
        return {a, DW'(8'h30)};
      end
    endcase
  endfunction

  function automatic string op_tag(input int op);
    case (op)
      0: return "R2 program sequence";
      1: return "R3 chip erase sequence";
      2: return "R4 block erase sequence";
      default: return "R5 sector erase sequence";
    endcase
  endfunction

  task automatic wait_done();
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (done) break;
    end
  endtask

  task automatic run_seq(input int op, input bit mode, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input bit interfere);
    int n = (op == 0) ? 4 : 6;
    mode_cur = mode; nw = 0; done_cnt = 0; busy_run = 0;
    @(negedge clk);
    req_op = 2'(op); req_addr = a; req_data = d; use_chip_strobe = mode; req_valid = 1'b1;
    @(negedge clk);
    if (interfere) begin
      req_op = 2'(op ^ 1); req_addr = ~a; req_data = ~d; use_chip_strobe = !mode;
      repeat (12) @(negedge clk);
    end
    req_valid = 1'b0;
    wait_done();
    @(negedge clk); #1;
    chk(nw == n, op_tag(op), nw, n);
    for (int i = 0; i < n; i++)
      chk(log_ad[i] === exp_ad(op, i, a, d), op_tag(op), log_ad[i], exp_ad(op, i, a, d));
    chk(done_cnt == 1, "R9 one done per request", done_cnt, 1);
    chk(lat_last == 2 * G + n * T, "R9 busy length", lat_last, 2 * G + n * T);
    if (interfere) chk(nw == n && done_cnt == 1, "R10 busy request ignored", nw, n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle pin state after reset
    chk({fl_chip_en_n, fl_write_en_n, fl_out_en_n} == 3'b111, "R1 idle strobes",
        {fl_chip_en_n, fl_write_en_n, fl_out_en_n}, 3'b111);
    chk({fl_protect_n, busy, done} == 3'b000, "R1 idle status",
        {fl_protect_n, busy, done}, 3'b000);

    for (int m = 0; m < 2; m++)
      for (int op = 0; op < 4; op++)
        for (int p = 0; p < 3; p++)
          run_seq(op, m[0], AW'(21'h1ABCDE ^ (p * 21'h0F0F1) ^ (op * 21'h3131)),
                  DW'(16'hBEEF ^ (p * 16'h1357) ^ (op << 12)), 1'b0);

    // R10: conflicting requests during busy
    run_seq(0, 1'b0, AW'(21'h0F00D), DW'(16'h1234), 1'b1);
    run_seq(3, 1'b1, AW'(21'h15555), DW'(16'hCAFE), 1'b1);

    // R10: request held through the done cycle is accepted right after it
    mode_cur = 1'b0; nw = 0; done_cnt = 0; busy_run = 0;
    @(negedge clk);
    req_op = 2'b00; req_addr = AW'(21'h00ABC); req_data = DW'(16'h5A5A);
    use_chip_strobe = 1'b0; req_valid = 1'b1;
    wait_done();
    @(negedge clk);
    chk(busy == 1'b1, "R10 request accepted at done", busy, 1);
    req_valid = 1'b0;
    wait_done();
    @(negedge clk); #1;
    chk(nw == 8, "R10 two full sequences", nw, 8);
    for (int i = 0; i < 8; i++)
      chk(log_ad[i] === exp_ad(0, i % 4, AW'(21'h00ABC), DW'(16'h5A5A)),
          "R10 back-to-back content", log_ad[i],
          exp_ad(0, i % 4, AW'(21'h00ABC), DW'(16'h5A5A)));
    chk(done_cnt == 2, "R10 two done pulses", done_cnt, 2);

    @(negedge clk);
    chk({fl_chip_en_n, fl_write_en_n, fl_protect_n, busy} == 4'b1100, "R1 idle after run",
        {fl_chip_en_n, fl_write_en_n, fl_protect_n, busy}, 4'b1100);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule